// File: doc/BRIEF.md
# Byte FIFO with Shared Water-Level Alerts

This block is a 64-entry, byte-wide FIFO. One programmable threshold drives two warnings. The high alert rises when too little free space is left. The low alert rises when too few bytes are stored. The threshold and a small control register sit behind a one-bit-address register port. Bytes enter and leave through a push/pop port. The head byte is always visible on the pop output.

A command bit in the control register starts an identifier load. The load copies a fixed ten-byte identifier (a parameter) into the FIFO at one byte per clock. The bit clears itself when the copy ends. Two further control bits are write-only strobes for an external timer. A read of the control register also returns a three-bit count, taken from an input, of the valid bits in the last received byte.

The loader is a two-state machine:
- `LD_IDLE` waits for a command write. The transition `start` leads to `LD_RUN`.
- `LD_RUN` pushes identifier byte `idx` on each cycle. The transition `last` (at `idx == ID_LEN-1`) returns it to `LD_IDLE`. Otherwise the transition `next` stays in `LD_RUN` and increments `idx`.

Top module: `wlf_fifo_top`

## Requirements
- R1: After reset:
  - the fill level is 0;
  - the threshold is 8;
  - both sticky flags are 0;
  - the initiator bit is 0;
  - the loader is idle;
  - the timer strobes are 0.
- R2: Register address 0 holds the threshold in bits 5:0. These bits can be written and read back. Bits 7:6 read as 0.
- R3: Bytes leave in the order they were pushed.
  - `pop_data` shows the head byte, or 0x00 when the FIFO is empty.
  - A push and a pop in the same cycle both take effect when the push finds space and the pop finds data. Both of these tests use the fill level from before the edge.
  - The fill level changes by at most 1 per cycle.
- R4: A push while the fill level is 64 is dropped, and `ovf_flag` is set. `ovf_flag` stays set until reset.
- R5: A pop while the fill level is 0 leaves the level at 0. It returns 0x00 and sets `unf_flag`, which stays set until reset.
- R6: `hi_alert` is 1 exactly when (64 − fill level) ≤ threshold.
- R7: `lo_alert` is 1 exactly when the fill level ≤ threshold.
- R8: Writing address 1 with bit 5 set while the loader is idle starts a load.
  - Identifier bytes 0 to 9 are pushed on the 10 clock edges that follow the write edge, one per edge.
  - Bit 5 of address 1 reads 1 during those 10 cycles and 0 afterwards.
  - Setting bit 5 again while a load runs has no effect.
- R9: While a load runs, the external push input is ignored. Identifier bytes that meet a full FIFO are dropped and set `ovf_flag`.
- R10: Writing address 1 with bit 6 (start) or bit 7 (stop) set gives a one-cycle pulse on `tmr_start` or `tmr_stop` in the cycle after the write. Both bits read as 0.
- R11: A read of address 1 returns:
  - bit 4: the initiator bit, which can be written and read back;
  - bit 3: 0;
  - bits 2:0: the `rx_last_bits` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 threshold, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rx_last_bits | input | 3 | Valid-bit count of last received byte |
| push | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request |
| pop_data | output | 8 | Head byte, or 0x00 when empty |
| fill_level | output | 7 | Bytes held (0 to 64) |
| hi_alert | output | 1 | Free space at or below threshold |
| lo_alert | output | 1 | Fill level at or below threshold |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| initiator | output | 1 | Initiator role bit |
| tmr_start | output | 1 | Timer start pulse |
| tmr_stop | output | 1 | Timer stop pulse |

## Verification
The bench uses the default parameters: depth 64, a 6-bit threshold and a ten-byte identifier. With these values, a full FIFO, overflow and the underflow corner can all be reached within about seventy pushes. Threshold values of 0, 8, 32 and 63 place the alert edges at empty, at full and at every point in between. Setting the fill level to 60 before a load leaves four free slots, so part of the identifier lands and the rest is dropped.

// File: rtl/wlf_pkg.sv
package wlf_pkg;
    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_t;

    localparam logic ADDR_LEVEL = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    localparam int CTRL_STOP_BIT  = 7;
    localparam int CTRL_START_BIT = 6;
    localparam int CTRL_LOAD_BIT  = 5;
    localparam int CTRL_INIT_BIT  = 4;
endpackage

// File: rtl/wlf_loader.sv
module wlf_loader
    import wlf_pkg::*;
#(
    parameter int              ID_LEN   = 10,
    parameter logic [ID_LEN*8-1:0] ID_BYTES = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       ld_req,
    output logic [7:0] ld_byte
);
    localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_LEN - 1);

    ld_state_t        state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // transitions: start, next, last
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            LD_IDLE: begin
                idx_nx = '0;
                if (start) state_nx = LD_RUN;
            end
            LD_RUN: begin
                if (idx == IDX_LAST) begin
                    state_nx = LD_IDLE;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx + 1'b1;
                end
            end
            default: state_nx = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        ld_req  = 1'b0;
        ld_byte = 8'h00;
        unique case (state)
            LD_IDLE: ;
            LD_RUN: begin
                busy    = 1'b1;
                ld_req  = 1'b1;
                ld_byte = ID_BYTES[idx*8 +: 8];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wlf_regs.sv
module wlf_regs
    import wlf_pkg::*;
#(
    parameter int         WL_W     = 6,
    parameter logic [WL_W-1:0] WL_RESET = WL_W'(8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic            reg_addr,
    input  logic [7:0]      reg_wdata,
    input  logic            busy,
    input  logic [2:0]      rx_last_bits,
    output logic [7:0]      reg_rdata,
    output logic [WL_W-1:0] wl_value,
    output logic            init_bit,
    output logic            start_load,
    output logic            tmr_start,
    output logic            tmr_stop
);
    logic wr_level, wr_ctrl;

    always_comb begin
        wr_level   = reg_we && (reg_addr == ADDR_LEVEL);
        wr_ctrl    = reg_we && (reg_addr == ADDR_CTRL);
        start_load = wr_ctrl && reg_wdata[CTRL_LOAD_BIT] && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_value  <= WL_RESET;
            init_bit  <= 1'b0;
            tmr_start <= 1'b0;
            tmr_stop  <= 1'b0;
        end else begin
            tmr_start <= wr_ctrl && reg_wdata[CTRL_START_BIT];
            tmr_stop  <= wr_ctrl && reg_wdata[CTRL_STOP_BIT];
            if (wr_level) wl_value <= reg_wdata[WL_W-1:0];
            if (wr_ctrl)  init_bit <= reg_wdata[CTRL_INIT_BIT];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_LEVEL) begin
            reg_rdata[WL_W-1:0] = wl_value;
        end else begin
            reg_rdata[CTRL_LOAD_BIT] = busy;
            reg_rdata[CTRL_INIT_BIT] = init_bit;
            reg_rdata[2:0]           = rx_last_bits;
        end
    end
endmodule

// File: rtl/wlf_store.sv
module wlf_store #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [7:0]       wr_byte,
    input  logic             rd_req,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] fill,
    output logic             ovf,
    output logic             unf
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_wr, do_rd, is_full, is_empty;

    always_comb begin
        is_full  = (fill == FULL);
        is_empty = (fill == '0);
        do_wr    = wr_req && !is_full;
        do_rd    = rd_req && !is_empty;
        rd_byte  = is_empty ? 8'h00 : mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            if (wr_req && is_full)  ovf <= 1'b1;
            if (rd_req && is_empty) unf <= 1'b1;
        end
    end
endmodule

// File: rtl/wlf_alerts.sv
module wlf_alerts #(
    parameter int DEPTH = 64,
    parameter int WL_W  = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = (CNT_W > WL_W) ? CNT_W : WL_W
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [WL_W-1:0]  wl_value,
    output logic             hi_alert,
    output logic             lo_alert
);
    logic [CMP_W-1:0] free_x, fill_x, wl_x;

    always_comb begin
        fill_x   = CMP_W'(fill);
        free_x   = CMP_W'(DEPTH) - fill_x;
        wl_x     = CMP_W'(wl_value);
        hi_alert = (free_x <= wl_x);
        lo_alert = (fill_x <= wl_x);
    end
endmodule

// File: rtl/wlf_fifo_top.sv
module wlf_fifo_top #(
    parameter int DEPTH  = 64,
    parameter int WL_W   = 6,
    parameter int WL_RST = 8,
    parameter int ID_LEN = 10,
    parameter logic [ID_LEN*8-1:0] ID_BYTES = 80'h9A8B7C6D5E4F30211203,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [2:0]       rx_last_bits,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       pop_data,
    output logic [CNT_W-1:0] fill_level,
    output logic             hi_alert,
    output logic             lo_alert,
    output logic             ovf_flag,
    output logic             unf_flag,
    output logic             initiator,
    output logic             tmr_start,
    output logic             tmr_stop
);
    logic            load_busy, start_load, ld_req, wr_req;
    logic [7:0]      ld_byte, wr_byte;
    logic [WL_W-1:0] wl_value;

    wlf_regs #(.WL_W(WL_W), .WL_RESET(WL_W'(WL_RST))) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(load_busy), .rx_last_bits(rx_last_bits),
        .reg_rdata(reg_rdata), .wl_value(wl_value), .init_bit(initiator),
        .start_load(start_load), .tmr_start(tmr_start), .tmr_stop(tmr_stop)
    );

    wlf_loader #(.ID_LEN(ID_LEN), .ID_BYTES(ID_BYTES)) u_loader (
        .clk(clk), .rst_n(rst_n), .start(start_load), .busy(load_busy),
        .ld_req(ld_req), .ld_byte(ld_byte)
    );

    // the loader owns the write side while it runs
    always_comb begin
        wr_req  = load_busy ? ld_req  : push;
        wr_byte = load_busy ? ld_byte : push_data;
    end

    wlf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_byte(wr_byte),
        .rd_req(pop), .rd_byte(pop_data), .fill(fill_level),
        .ovf(ovf_flag), .unf(unf_flag)
    );

    wlf_alerts #(.DEPTH(DEPTH), .WL_W(WL_W)) u_alerts (
        .fill(fill_level), .wl_value(wl_value),
        .hi_alert(hi_alert), .lo_alert(lo_alert)
    );
endmodule

// File: rtl/wlf_checker.sv
module wlf_checker #(
    parameter int DEPTH = 64,
    parameter int WL_W  = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             push,
    input logic             pop,
    input logic [CNT_W-1:0] fill_level,
    input logic             hi_alert,
    input logic             lo_alert,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             load_busy,
    input logic [WL_W-1:0]  wl_value,
    input logic             tmr_start
);
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));

    p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((CNT_W+1)'(fill_level) <= (CNT_W+1)'($past(fill_level)) + 1'b1) &&
                 ((CNT_W+1)'(fill_level) + 1'b1 >= (CNT_W+1)'($past(fill_level))));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == CNT_W'(DEPTH)) && push && !pop |=> (fill_level == CNT_W'(DEPTH)) && ovf_flag);

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) && pop && !push && !load_busy |=> (fill_level == '0) && unf_flag);

    p_unf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    p_alert_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wl_value) * 2 < DEPTH) |-> !(hi_alert && lo_alert));

    p_load_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_busy) |-> $past(reg_we && reg_addr && reg_wdata[5]));

    p_tmr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> $past(reg_we && reg_addr && reg_wdata[6]));
endmodule

bind wlf_fifo_top wlf_checker #(.DEPTH(DEPTH), .WL_W(WL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .push(push), .pop(pop), .fill_level(fill_level),
    .hi_alert(hi_alert), .lo_alert(lo_alert), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .load_busy(load_busy), .wl_value(wl_value),
    .tmr_start(tmr_start)
);

// File: tb/sim_wlf_fifo_top.sv
`timescale 1ns/1ps
module sim_wlf_fifo_top;
    localparam logic [79:0] ID_VAL = 80'h9A8B7C6D5E4F30211203;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [2:0] rx_last_bits = 3'd0;
    logic       push = 1'b0, pop = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] reg_rdata, pop_data;
    logic [6:0] fill_level;
    logic       hi_alert, lo_alert, ovf_flag, unf_flag, initiator, tmr_start, tmr_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wlf_fifo_top #(.DEPTH(64), .WL_W(6), .WL_RST(8), .ID_LEN(10), .ID_BYTES(ID_VAL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_last_bits(rx_last_bits),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .fill_level(fill_level), .hi_alert(hi_alert), .lo_alert(lo_alert),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .initiator(initiator),
        .tmr_start(tmr_start), .tmr_stop(tmr_stop)
    );

    // behavioural reference
    logic [7:0] q[$];
    int  m_wl = 8, m_idx = 0;
    bit  m_busy = 0, m_init = 0, m_ovf = 0, m_unf = 0, m_ts = 0, m_tp = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit wreq, pok, wok;
        logic [7:0] wb;
        int sz, fre, rd_exp;
        if (!rst_n) begin
            q.delete(); m_wl = 8; m_idx = 0; m_busy = 0; m_init = 0;
            m_ovf = 0; m_unf = 0; m_ts = 0; m_tp = 0;
        end else begin
            sz   = q.size();
            wreq = m_busy ? 1'b1 : push;
            wb   = m_busy ? ID_VAL[8*m_idx +: 8] : push_data;
            pok  = pop && sz > 0;
            wok  = wreq && sz < 64;
            if (pop && sz == 0) m_unf = 1;
            if (wreq && sz == 64) m_ovf = 1;
            if (pok) void'(q.pop_front());
            if (wok) q.push_back(wb);
            if (m_busy) begin
                if (m_idx == 9) begin m_busy = 0; m_idx = 0; end
                else m_idx++;
            end else if (reg_we && reg_addr && reg_wdata[5]) begin
                m_busy = 1; m_idx = 0;
            end
            m_ts = reg_we && reg_addr && reg_wdata[6];
            m_tp = reg_we && reg_addr && reg_wdata[7];
            if (reg_we && !reg_addr) m_wl = int'(reg_wdata[5:0]);
            if (reg_we && reg_addr)  m_init = reg_wdata[4];
        end
        #2;
        if (!done) begin
            sz  = q.size();
            fre = 64 - sz;
            chk(rst_n ? "R3" : "R1", "fill_level", int'(fill_level), sz);
            chk("R3", "pop_data", int'(pop_data), sz > 0 ? int'(q[0]) : 0);
            chk("R6", "hi_alert", int'(hi_alert), int'(fre <= m_wl));
            chk("R7", "lo_alert", int'(lo_alert), int'(sz <= m_wl));
            chk("R4", "ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk("R5", "unf_flag", int'(unf_flag), int'(m_unf));
            chk("R11", "initiator", int'(initiator), int'(m_init));
            chk("R10", "tmr_start", int'(tmr_start), int'(m_ts));
            chk("R10", "tmr_stop", int'(tmr_stop), int'(m_tp));
            if (!reg_addr) begin
                rd_exp = m_wl;
                chk("R2", "level readback", int'(reg_rdata), rd_exp);
            end else begin
                rd_exp = (int'(m_busy) << 5) | (int'(m_init) << 4) | int'(rx_last_bits);
                chk("R8", "control readback", int'(reg_rdata), rd_exp);
            end
        end
    end

    task automatic step(input bit p, input logic [7:0] d, input bit pp,
                        input bit we, input bit a, input logic [7:0] wd);
        @(negedge clk);
        push = p; push_data = d; pop = pp;
        reg_we = we; reg_addr = a; reg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, reg_addr, 8'h00);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset values observed while held and after release
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2: threshold write, reserved bits read 0
        step(0, 0, 0, 1, 0, 8'hFF); idle(2);
        step(0, 0, 0, 1, 0, 8'h08); idle(1);
        // R3: order, simultaneous push/pop
        for (int i = 0; i < 5; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 8'(8'h40 + i), 1, 0, 0, 0);
        idle(1);
        // R4: fill past 64
        for (int i = 0; i < 62; i++) step(1, 8'(i * 3), 0, 0, 0, 0);
        step(1, 8'hAA, 1, 0, 0, 0);
        idle(1);
        // R6, R7: threshold edges at full
        step(0, 0, 0, 1, 0, 8'd0);  idle(1);
        step(0, 0, 0, 1, 0, 8'd63); idle(1);
        step(0, 0, 0, 1, 0, 8'd32); idle(1);
        // R5: drain and pop past empty
        for (int i = 0; i < 68; i++) step(0, 0, 1, 0, 0, 0);
        step(1, 8'h77, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        idle(1);
        // R11: control readback with initiator and rx_last_bits
        rx_last_bits = 3'd5;
        step(0, 0, 0, 1, 1, 8'h18); idle(2);
        rx_last_bits = 3'd0;
        step(0, 0, 0, 1, 1, 8'h08); idle(1);
        // R10: timer strobes
        step(0, 0, 0, 1, 1, 8'h40); step(0, 0, 0, 1, 1, 8'h80); idle(2);
        // R8, R9: load into empty FIFO with pushes attempted meanwhile
        step(0, 0, 0, 1, 1, 8'h30);
        for (int i = 0; i < 10; i++) step(1, 8'hEE, 0, (i == 3), 1, 8'h20);
        idle(2);
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 1, 0);
        // R9: load with only four free slots
        for (int i = 0; i < 60; i++) step(1, 8'(i), 0, 0, 1, 0);
        step(0, 0, 0, 1, 1, 8'h20);
        idle(12);
        step(0, 0, 0, 1, 0, 8'd8); idle(1);
        for (int i = 0; i < 66; i++) step(0, 0, 1, 0, 0, 0);
        idle(2);
        summary();
    end
endmodule